// File: doc/BRIEF.md
# LCD Controller Command Decoder and Display RAM Address Unit

This block sits behind the 8-bit parallel host port of a dot-matrix LCD controller. The host presents a byte on the data inputs along with a data/command select, a read/write select and a chip enable, and then produces a falling edge on the strobe input. The block samples the byte on that edge. Command bytes are decoded into configuration registers or pointer moves. Data bytes are written into, or read from, a display memory of 5 pages by 120 columns of bytes. That memory is held as a plain internal array.

The unit keeps a page pointer and a column pointer. The column pointer advances after every data access, and the host can save it and later restore it. Two clear commands each arm a wipe of the memory. The wipe starts on the next data write, which is taken as a dummy. The contrast level can be read back through a command read. Bits that only configure the analog section are stored and presented at the outputs unchanged.

The strobe input is taken to be synchronous to the system clock. A falling edge is the first cycle in which the strobe is low after a cycle in which it was high.

Top module: `lcd_cmd_unit`

## Requirements
- R1: A byte is accepted only on a strobe falling edge while `ce_i` is high and `busy_o` is low. With `dc_i` low it is a command, and with `dc_i` high it is display data. `rw_i` high means read and low means write. When `ce_i` is low, the edge has no effect.
- R2: The command `1ccccccc` loads the column pointer with `ccccccc`. A value above 119 is clamped to 119.
- R3: The command `00000ppp` with ppp from 0 to 4 loads `page_o` with ppp, where 0 is the first page. Values 5 to 7 are ignored. After reset the page is 0.
- R4: A data write stores the byte at the current page and column, then advances the column by one. The column wraps from 119 to 0 and the page does not change.
- R5: A data read puts the byte stored at the current page and column on `dout_o`. One cycle after the accepting edge, `rd_valid_o` pulses high for one cycle. The column then advances as in R4.
- R6: No command access moves the column pointer, except the set-column command (R2) and restore (R7).
- R7: The command 0x35 copies the column pointer into a save register. The command 0x34 copies the saved value back into the column pointer. The save register resets to 0.
- R8: After the command 0x36, the next data write is a dummy. It stores nothing and does not advance the column. It starts a wipe that zeroes pages 0 to 3 at one byte per cycle. `busy_o` stays high for 480 cycles, and any access made during that time is ignored.
- R9: After the command 0x37, the next data write is likewise a dummy. It zeroes page 4 only, and `busy_o` stays high for 120 cycles.
- R10: The command `0001cccc` loads the 4-bit contrast level, which resets to 0. The command 0x71 steps the level up by one and 0x70 steps it down by one, wrapping between 15 and 0.
- R11: A command read whose data bits 7..4 are 0001 returns the contrast level on `dout_o`, with bits 7..4 at zero, and pulses `rd_valid_o`. Any other command read does not pulse `rd_valid_o`.
- R12: The command `010sssss` loads the 5-bit `scroll_o`. The command 0x68 clears `duty16_o` and 0x69 sets it. Both reset to 0.
- R13: The command `001iiiix` with i from 0 to 9 and i not equal to 3 writes x into bit i of `cfg_o`. `cfg_o` resets to all zeros.
- R14: All other command codes leave every output and pointer unchanged. These are 0x08–0x0F, 0x26–0x27, 0x38–0x3F, 0x60–0x67, 0x6A–0x6F and 0x72–0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable for the host port |
| stb_i | input | 1 | Host strobe; the byte is taken on its falling edge |
| dc_i | input | 1 | 1 = display data, 0 = command |
| rw_i | input | 1 | 1 = read, 0 = write |
| din_i | input | 8 | Byte from the host |
| dout_o | output | 8 | Byte returned by the last read |
| rd_valid_o | output | 1 | One-cycle pulse when `dout_o` carries a fresh read result |
| busy_o | output | 1 | Memory wipe in progress |
| page_o | output | 3 | Current page pointer |
| col_o | output | 7 | Current column pointer |
| contrast_o | output | 4 | Contrast level |
| scroll_o | output | 5 | Vertical scroll value |
| duty16_o | output | 1 | 1/16 duty selected |
| cfg_o | output | 10 | Stored analog configuration bits |

## Verification
Writes followed by read-back are placed at several columns: at column 0, mid-row, and at column 119. The last of these separates correct wrap-around from an off-by-one or a page carry. Column loads above 119 test the clamp. Save and restore are done with a different column loaded in between, so a restore that did nothing would be caught.

The two wipes are run on memory that holds known bytes on both sides of the page boundary, which shows whether the icon wipe spares pages 0 to 3. A pointer command sent during the wipe shows whether host accesses are locked out. Contrast steps across 15 and 0 test the wrap. A run of reserved codes, a command read with the wrong upper nibble, and a write with chip enable low each confirm that the stimulus changes nothing observable.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    localparam int BYTE_W     = 8;
    localparam int CON_W      = 4;
    localparam int SCR_W      = 5;
    localparam int FLAG_N     = 10;
    localparam int FLAG_RESV  = 3;
    localparam int GRP_SAVE   = 10;
    localparam int GRP_CLEAR  = 11;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_SET_COL,
        OP_SET_PAGE,
        OP_SET_CON,
        OP_STEP_CON,
        OP_FLAG,
        OP_SAVE_REST,
        OP_CLEAR,
        OP_SCROLL,
        OP_DUTY
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [6:0] arg;
    } cmd_t;

endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
    import lcd_cmd_pkg::*;
#(
    parameter int NUM_PAGES = 5
) (
    input  logic [BYTE_W-1:0] byte_i,
    output cmd_t              cmd_o
);

    logic [3:0] grp;

    always_comb begin
        cmd_o.op  = OP_NONE;
        cmd_o.arg = byte_i[6:0];
        grp       = byte_i[4:1];
        casez (byte_i)
            8'b1???_????: cmd_o.op = OP_SET_COL;
            8'b0000_0???: begin
                if (int'(byte_i[2:0]) < NUM_PAGES) cmd_o.op = OP_SET_PAGE;
            end
            8'b0001_????: cmd_o.op = OP_SET_CON;
            8'b001?_????: begin
                if (int'(grp) < FLAG_N && int'(grp) != FLAG_RESV)
                    cmd_o.op = OP_FLAG;
                else if (int'(grp) == GRP_SAVE)
                    cmd_o.op = OP_SAVE_REST;
                else if (int'(grp) == GRP_CLEAR)
                    cmd_o.op = OP_CLEAR;
            end
            8'b010?_????: cmd_o.op = OP_SCROLL;
            8'b0110_100?: cmd_o.op = OP_DUTY;
            8'b0111_000?: cmd_o.op = OP_STEP_CON;
            default:      cmd_o.op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/lcd_page_ram.sv
module lcd_page_ram #(
    parameter  int NUM_PAGES = 5,
    parameter  int NUM_COLS  = 120,
    parameter  int DATA_W    = 8,
    localparam int PG_W      = $clog2(NUM_PAGES),
    localparam int COL_W     = $clog2(NUM_COLS)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [PG_W-1:0]   wpage_i,
    input  logic [COL_W-1:0]  wcol_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PG_W-1:0]   rpage_i,
    input  logic [COL_W-1:0]  rcol_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = NUM_PAGES * NUM_COLS;
    localparam int AW    = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;

    assign waddr   = AW'(wpage_i) * AW'(NUM_COLS) + AW'(wcol_i);
    assign raddr   = AW'(rpage_i) * AW'(NUM_COLS) + AW'(rcol_i);
    assign rdata_o = mem[raddr];

    always_ff @(posedge clk_i) begin
        if (we_i) mem[waddr] <= wdata_i;
    end

endmodule

// File: rtl/lcd_clear_sweep.sv
module lcd_clear_sweep #(
    parameter  int NUM_PAGES = 5,
    parameter  int NUM_COLS  = 120,
    localparam int PG_W      = $clog2(NUM_PAGES),
    localparam int COL_W     = $clog2(NUM_COLS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             icon_i,
    output logic             busy_o,
    output logic             we_o,
    output logic [PG_W-1:0]  page_o,
    output logic [COL_W-1:0] col_o
);

    localparam logic [PG_W-1:0]  ICON_PG   = PG_W'(NUM_PAGES - 1);
    localparam logic [PG_W-1:0]  MAIN_LAST = PG_W'(NUM_PAGES - 2);
    localparam logic [COL_W-1:0] COL_LAST  = COL_W'(NUM_COLS - 1);

    typedef struct packed {
        logic             active;
        logic [PG_W-1:0]  page;
        logic [PG_W-1:0]  last;
        logic [COL_W-1:0] col;
    } sweep_t;

    sweep_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.active) begin
            if (s_q.col == COL_LAST) begin
                s_d.col = '0;
                if (s_q.page == s_q.last) s_d.active = 1'b0;
                else                      s_d.page   = s_q.page + 1'b1;
            end else begin
                s_d.col = s_q.col + 1'b1;
            end
        end else if (start_i) begin
            s_d.active = 1'b1;
            s_d.col    = '0;
            s_d.page   = icon_i ? ICON_PG : '0;
            s_d.last   = icon_i ? ICON_PG : MAIN_LAST;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o = s_q.active;
    assign we_o   = s_q.active;
    assign page_o = s_q.page;
    assign col_o  = s_q.col;

endmodule

// File: rtl/lcd_cmd_unit.sv
module lcd_cmd_unit
    import lcd_cmd_pkg::*;
#(
    parameter  int NUM_PAGES = 5,
    parameter  int NUM_COLS  = 120,
    localparam int PG_W      = $clog2(NUM_PAGES),
    localparam int COL_W     = $clog2(NUM_COLS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_i,
    input  logic              stb_i,
    input  logic              dc_i,
    input  logic              rw_i,
    input  logic [BYTE_W-1:0] din_i,
    output logic [BYTE_W-1:0] dout_o,
    output logic              rd_valid_o,
    output logic              busy_o,
    output logic [PG_W-1:0]   page_o,
    output logic [COL_W-1:0]  col_o,
    output logic [CON_W-1:0]  contrast_o,
    output logic [SCR_W-1:0]  scroll_o,
    output logic              duty16_o,
    output logic [FLAG_N-1:0] cfg_o
);

    localparam logic [COL_W-1:0] COL_MAX = COL_W'(NUM_COLS - 1);

    typedef struct packed {
        logic              stb;
        logic [PG_W-1:0]   page;
        logic [COL_W-1:0]  col;
        logic [COL_W-1:0]  col_save;
        logic [CON_W-1:0]  contrast;
        logic [SCR_W-1:0]  scroll;
        logic              duty16;
        logic [FLAG_N-1:0] cfg;
        logic              clr_pend;
        logic              clr_icon;
        logic [BYTE_W-1:0] dout;
        logic              rd_valid;
    } core_t;

    core_t c_d, c_q;

    cmd_t              cmd;
    logic              take;
    logic              host_we;
    logic              clr_start;
    logic              sw_busy;
    logic              sw_we;
    logic [PG_W-1:0]   sw_page;
    logic [COL_W-1:0]  sw_col;
    logic              ram_we;
    logic [PG_W-1:0]   ram_wpage;
    logic [COL_W-1:0]  ram_wcol;
    logic [BYTE_W-1:0] ram_wdata;
    logic [BYTE_W-1:0] ram_rdata;

    function automatic logic [COL_W-1:0] col_next(input logic [COL_W-1:0] c);
        return (c == COL_MAX) ? '0 : c + 1'b1;
    endfunction

    lcd_cmd_decode #(
        .NUM_PAGES (NUM_PAGES)
    ) dec_i (
        .byte_i (din_i),
        .cmd_o  (cmd)
    );

    lcd_clear_sweep #(
        .NUM_PAGES (NUM_PAGES),
        .NUM_COLS  (NUM_COLS)
    ) sweep_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (clr_start),
        .icon_i  (c_q.clr_icon),
        .busy_o  (sw_busy),
        .we_o    (sw_we),
        .page_o  (sw_page),
        .col_o   (sw_col)
    );

    lcd_page_ram #(
        .NUM_PAGES (NUM_PAGES),
        .NUM_COLS  (NUM_COLS),
        .DATA_W    (BYTE_W)
    ) ram_i (
        .clk_i   (clk_i),
        .we_i    (ram_we),
        .wpage_i (ram_wpage),
        .wcol_i  (ram_wcol),
        .wdata_i (ram_wdata),
        .rpage_i (c_q.page),
        .rcol_i  (c_q.col),
        .rdata_o (ram_rdata)
    );

    // next-state logic for the host side
    always_comb begin
        c_d          = c_q;
        c_d.stb      = stb_i;
        c_d.rd_valid = 1'b0;
        host_we      = 1'b0;
        clr_start    = 1'b0;
        take         = c_q.stb & ~stb_i & ce_i & ~sw_busy;

        if (take) begin
            case ({dc_i, rw_i})
                2'b10: begin
                    if (c_q.clr_pend) begin
                        clr_start    = 1'b1;
                        c_d.clr_pend = 1'b0;
                    end else begin
                        host_we = 1'b1;
                        c_d.col = col_next(c_q.col);
                    end
                end
                2'b11: begin
                    c_d.dout     = ram_rdata;
                    c_d.rd_valid = 1'b1;
                    c_d.col      = col_next(c_q.col);
                end
                2'b01: begin
                    if (din_i[7:4] == 4'b0001) begin
                        c_d.dout     = BYTE_W'(c_q.contrast);
                        c_d.rd_valid = 1'b1;
                    end
                end
                default: begin
                    case (cmd.op)
                        OP_SET_COL: begin
                            if (int'(cmd.arg) > NUM_COLS - 1) c_d.col = COL_MAX;
                            else                              c_d.col = COL_W'(cmd.arg);
                        end
                        OP_SET_PAGE:  c_d.page     = PG_W'(cmd.arg[2:0]);
                        OP_SET_CON:   c_d.contrast = cmd.arg[3:0];
                        OP_STEP_CON: begin
                            if (cmd.arg[0]) c_d.contrast = c_q.contrast + 1'b1;
                            else            c_d.contrast = c_q.contrast - 1'b1;
                        end
                        OP_FLAG:      c_d.cfg[cmd.arg[4:1]] = cmd.arg[0];
                        OP_SAVE_REST: begin
                            if (cmd.arg[0]) c_d.col_save = c_q.col;
                            else            c_d.col      = c_q.col_save;
                        end
                        OP_CLEAR: begin
                            c_d.clr_pend = 1'b1;
                            c_d.clr_icon = cmd.arg[0];
                        end
                        OP_SCROLL:    c_d.scroll = cmd.arg[4:0];
                        OP_DUTY:      c_d.duty16 = cmd.arg[0];
                        default:      ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    // memory write port: the wipe owns it while running, the host otherwise
    assign ram_we    = host_we | sw_we;
    assign ram_wpage = sw_we ? sw_page : c_q.page;
    assign ram_wcol  = sw_we ? sw_col  : c_q.col;
    assign ram_wdata = sw_we ? '0      : din_i;

    assign dout_o     = c_q.dout;
    assign rd_valid_o = c_q.rd_valid;
    assign busy_o     = sw_busy;
    assign page_o     = c_q.page;
    assign col_o      = c_q.col;
    assign contrast_o = c_q.contrast;
    assign scroll_o   = c_q.scroll;
    assign duty16_o   = c_q.duty16;
    assign cfg_o      = c_q.cfg;

endmodule

// File: rtl/lcd_cmd_unit_chk.sv
module lcd_cmd_unit_chk
    import lcd_cmd_pkg::*;
#(
    parameter  int NUM_PAGES = 5,
    parameter  int NUM_COLS  = 120,
    localparam int PG_W      = $clog2(NUM_PAGES),
    localparam int COL_W     = $clog2(NUM_COLS)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ce_i,
    input logic              stb_i,
    input logic              dc_i,
    input logic              rw_i,
    input logic [BYTE_W-1:0] din_i,
    input logic              rd_valid_o,
    input logic              busy_o,
    input logic [PG_W-1:0]   page_o,
    input logic [COL_W-1:0]  col_o,
    input logic [CON_W-1:0]  contrast_o,
    input logic [SCR_W-1:0]  scroll_o,
    input logic              duty16_o,
    input logic [FLAG_N-1:0] cfg_o
);

    localparam logic [COL_W-1:0] COL_MAX = COL_W'(NUM_COLS - 1);

    logic stb_prev;
    logic acc;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stb_prev <= 1'b0;
        else         stb_prev <= stb_i;
    end

    assign acc = stb_prev & ~stb_i & ce_i & ~busy_o;

    AST_COL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(col_o) < NUM_COLS);                                              // R2

    AST_PAGE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(page_o) < NUM_PAGES);                                            // R3

    AST_QUIET_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc |=> $stable(col_o) && $stable(page_o) && $stable(contrast_o)
                 && $stable(scroll_o) && $stable(duty16_o) && $stable(cfg_o)); // R1

    AST_READ_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc && dc_i && rw_i |=>
            col_o == (($past(col_o) == COL_MAX) ? '0 : $past(col_o) + 1'b1)); // R5

    AST_VALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> $past(acc && rw_i));                                   // R5

    AST_CMD_READ_HOLDS_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc && !dc_i && rw_i |=> $stable(col_o));                             // R6

    AST_STEP_UP_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc && !dc_i && !rw_i && din_i == 8'h71 |=>
            contrast_o == $past(contrast_o) + 4'd1);                          // R10

    AST_BUSY_FREEZES_PTRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(col_o) && $stable(page_o));                        // R8

endmodule

bind lcd_cmd_unit lcd_cmd_unit_chk #(
    .NUM_PAGES (NUM_PAGES),
    .NUM_COLS  (NUM_COLS)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_i       (ce_i),
    .stb_i      (stb_i),
    .dc_i       (dc_i),
    .rw_i       (rw_i),
    .din_i      (din_i),
    .rd_valid_o (rd_valid_o),
    .busy_o     (busy_o),
    .page_o     (page_o),
    .col_o      (col_o),
    .contrast_o (contrast_o),
    .scroll_o   (scroll_o),
    .duty16_o   (duty16_o),
    .cfg_o      (cfg_o)
);

// File: tb/lcd_cmd_unit_tb_top.sv
module lcd_cmd_unit_tb_top;

    localparam int NP = 5;
    localparam int NC = 120;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce    = 1'b0;
    logic       stb   = 1'b0;
    logic       dc    = 1'b0;
    logic       rw    = 1'b0;
    logic [7:0] din   = 8'h00;

    logic [7:0] dout;
    logic       rd_valid;
    logic       busy;
    logic [2:0] page;
    logic [6:0] col;
    logic [3:0] contrast;
    logic [4:0] scroll;
    logic       duty16;
    logic [9:0] cfg;

    always #10 clk = ~clk;

    lcd_cmd_unit dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ce_i       (ce),
        .stb_i      (stb),
        .dc_i       (dc),
        .rw_i       (rw),
        .din_i      (din),
        .dout_o     (dout),
        .rd_valid_o (rd_valid),
        .busy_o     (busy),
        .page_o     (page),
        .col_o      (col),
        .contrast_o (contrast),
        .scroll_o   (scroll),
        .duty16_o   (duty16),
        .cfg_o      (cfg)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // behavioural reference model, updated at each rising edge
    int         m_page, m_col, m_save, m_con, m_scroll, m_busy;
    bit         m_duty, m_pend, m_icon, m_rv, m_stb_prev;
    logic [9:0] m_cfg;
    logic [7:0] m_dout;
    logic [7:0] m_mem [NP*NC];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_page = 0; m_col = 0; m_save = 0; m_con = 0; m_scroll = 0; m_busy = 0;
            m_duty = 0; m_pend = 0; m_icon = 0; m_rv = 0; m_stb_prev = 0;
            m_cfg = '0; m_dout = 8'h00;
        end else begin
            bit fall;
            fall = m_stb_prev && !stb && ce;
            m_stb_prev = stb;
            m_rv = 0;
            if (m_busy > 0) begin
                m_busy--;
            end else if (fall) begin
                if (dc && !rw) begin
                    if (m_pend) begin
                        int first, last;
                        first = m_icon ? NP - 1 : 0;
                        last  = m_icon ? NP - 1 : NP - 2;
                        for (int p = first; p <= last; p++)
                            for (int c = 0; c < NC; c++) m_mem[p*NC + c] = 8'h00;
                        m_busy = (last - first + 1) * NC;
                        m_pend = 0;
                    end else begin
                        m_mem[m_page*NC + m_col] = din;
                        m_col = (m_col + 1) % NC;
                    end
                end else if (dc && rw) begin
                    m_dout = m_mem[m_page*NC + m_col];
                    m_rv = 1;
                    m_col = (m_col + 1) % NC;
                end else if (!dc && rw) begin
                    if (din[7:4] == 4'h1) begin
                        m_dout = 8'(m_con);
                        m_rv = 1;
                    end
                end else begin
                    int v;
                    v = int'(din);
                    if (v >= 128) begin
                        m_col = (v - 128 > NC - 1) ? NC - 1 : v - 128;
                    end else if (v < 8) begin
                        if (v < NP) m_page = v;
                    end else if (v >= 16 && v < 32) begin
                        m_con = v - 16;
                    end else if (v >= 32 && v < 64) begin
                        int k;
                        k = (v - 32) / 2;
                        if (k < 10 && k != 3)  m_cfg[k] = din[0];
                        else if (k == 10) begin
                            if (din[0]) m_save = m_col;
                            else        m_col  = m_save;
                        end else if (k == 11) begin
                            m_pend = 1;
                            m_icon = din[0];
                        end
                    end else if (v >= 64 && v < 96) begin
                        m_scroll = v - 64;
                    end else if (v == 8'h68 || v == 8'h69) begin
                        m_duty = din[0];
                    end else if (v == 8'h70 || v == 8'h71) begin
                        m_con = (m_con + (din[0] ? 1 : 15)) % 16;
                    end
                end
            end
        end
    end

    // compare the design with the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 model page",     page,     m_page);
            check("R4 model col",      col,      m_col);
            check("R10 model contrast", contrast, m_con);
            check("R12 model scroll",  scroll,   m_scroll);
            check("R12 model duty",    duty16,   m_duty);
            check("R13 model cfg",     cfg,      m_cfg);
            check("R8 model busy",     busy,     (m_busy > 0));
            check("R5 model rd_valid", rd_valid, m_rv);
            if (m_rv) check("R5 model dout", dout, m_dout);
        end
    end

    task automatic bus(input bit c_en, input bit d, input bit r, input logic [7:0] b);
        @(negedge clk);
        ce = c_en; dc = d; rw = r; din = b; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        @(negedge clk);
        ce = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);  bus(1'b1, 1'b0, 1'b0, b);    endtask
    task automatic wr(input logic [7:0] b);   bus(1'b1, 1'b1, 1'b0, b);    endtask
    task automatic rd();                      bus(1'b1, 1'b1, 1'b1, 8'h00); endtask
    task automatic creg(input logic [7:0] b); bus(1'b1, 1'b0, 1'b1, b);    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired before the sequence completed");
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset page",     page,     0);
        check("R4 reset col",      col,      0);
        check("R10 reset contrast", contrast, 0);
        check("R12 reset scroll",  scroll,   0);
        check("R12 reset duty",    duty16,   0);
        check("R13 reset cfg",     cfg,      0);

        // wipe the whole memory so every byte is known
        cmd(8'h36);
        wr(8'hAA);
        check("R8 dummy write keeps col", col, 0);
        check("R8 busy after dummy",      busy, 1);
        wait_idle();
        cmd(8'h37);
        wr(8'h00);
        check("R9 busy after icon dummy", busy, 1);
        wait_idle();
        cmd(8'h80);
        rd();
        check("R8 wiped byte", dout, 8'h00);

        // column load, writes, read-back
        cmd(8'h85);
        check("R2 col load", col, 5);
        wr(8'h11);
        wr(8'h22);
        check("R4 col after two writes", col, 7);
        cmd(8'h85);
        rd();
        check("R5 read data",     dout,     8'h11);
        check("R5 read valid",    rd_valid, 1);
        check("R5 col after read", col,     6);

        // clamp and wrap
        cmd(8'hFF);
        check("R2 clamp to 119", col, 119);
        wr(8'h33);
        check("R4 wrap to 0",   col,  0);
        check("R4 page kept",   page, 0);
        cmd(8'hF7);
        rd();
        check("R4 byte at col 119", dout, 8'h33);

        // page pointer
        cmd(8'h02);
        check("R3 page load", page, 2);
        cmd(8'h06);
        check("R3 out-of-range page ignored", page, 2);

        // save and restore
        cmd(8'h8A);
        cmd(8'h35);
        cmd(8'h94);
        check("R7 col moved", col, 20);
        cmd(8'h34);
        check("R7 restore", col, 10);

        // contrast
        cmd(8'h1F);
        check("R10 load", contrast, 15);
        cmd(8'h71);
        check("R10 step up wraps", contrast, 0);
        cmd(8'h70);
        check("R10 step down wraps", contrast, 15);
        creg(8'h10);
        check("R11 contrast readback", dout,     8'h0F);
        check("R11 readback valid",    rd_valid, 1);
        check("R6 command read keeps col", col, 10);
        creg(8'h20);
        check("R11 other command read no valid", rd_valid, 0);

        // scroll, duty, configuration bits
        cmd(8'h5A);
        check("R12 scroll", scroll, 26);
        cmd(8'h69);
        check("R12 duty", duty16, 1);
        cmd(8'h29);
        check("R13 cfg bit 4", cfg, 10'h010);
        cmd(8'h27);
        check("R14 reserved flag slot", cfg, 10'h010);

        // reserved codes
        cmd(8'h0C);
        cmd(8'h3A);
        cmd(8'h75);
        cmd(8'h62);
        cmd(8'h0B);
        check("R14 col",      col,      10);
        check("R14 page",     page,     2);
        check("R14 contrast", contrast, 15);
        check("R14 scroll",   scroll,   26);
        check("R14 duty",     duty16,   1);
        check("R14 cfg",      cfg,      10'h010);

        // chip enable low
        bus(1'b0, 1'b1, 1'b0, 8'h99);
        check("R1 ce low col", col, 10);
        rd();
        check("R1 ce low no store", dout, 8'h00);

        // icon wipe spares the main pages
        cmd(8'h04);
        cmd(8'h83);
        wr(8'h44);
        cmd(8'h00);
        cmd(8'h83);
        wr(8'h55);
        cmd(8'h37);
        wr(8'h00);
        check("R8 icon dummy keeps col", col, 4);
        wait_idle();
        cmd(8'h04);
        cmd(8'h83);
        rd();
        check("R9 icon page wiped", dout, 8'h00);
        cmd(8'h00);
        cmd(8'h83);
        rd();
        check("R9 main page kept", dout, 8'h55);

        // access during the wipe is ignored
        cmd(8'h36);
        wr(8'h00);
        cmd(8'hB2);
        check("R8 access during busy ignored", col, 4);
        wait_idle();
        rd();
        check("R8 main page wiped", dout, 8'h00);

        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule